// File: doc/BRIEF.md
# Immediate Operand Generator

This combinational block turns a 32-bit instruction word and a 4-bit operand-select code into a 64-bit immediate operand and a valid flag. Field positions are given in big-endian bit numbering, where bit 0 is the most significant bit of the word. For a numbered bit b, the port bit is `insn[31-b]`.

For each select code, the block takes the field the code names. It then shifts that field, zero-extends or sign-extends it, or replaces it with a constant. The result feeds the second operand of an execution unit. Codes that pick a register or a special register, or no operand at all, produce no immediate. For those codes the flag is low and the data is zero.

Select codes: 0 none, 1 register, 2 special register, 3 low unsigned, 4 low signed, 5 high unsigned, 6 high signed, 7 long branch, 8 branch displacement, 9 doubleword displacement, 10 minus one, 11 six-bit shift, 12 five-bit shift. Codes 13 to 15 are not defined.

Top module: `imm_operand_gen`

## Requirements
- R1: With select 3, `imm_data` is `insn[15:0]` (bits 16–31) zero-extended to 64 bits.
- R2: With select 4, `imm_data` is `insn[15:0]` sign-extended from `insn[15]` to 64 bits.
- R3: With select 5, `imm_data` is `insn[15:0]` shifted left by 16, with bits 63:32 zero.
- R4: With select 6, `imm_data` is `insn[15:0]` shifted left by 16 and then sign-extended from bit 31, so bits 63:32 all equal `insn[15]`.
- R5: With select 7, `imm_data` is the 24-bit field `insn[25:2]` (bits 6–29) shifted left by 2, and zero-extended.
- R6: With select 8 or 9, `imm_data` is the 14-bit field `insn[15:2]` (bits 16–29) shifted left by 2, and zero-extended.
- R7: With select 10, `imm_data` is all ones.
- R8: With select 11, `imm_data` is the 6-bit value `{insn[1], insn[15:11]}`, so bit 30 becomes result bit 5. Bits 63:6 are zero.
- R9: With select 12, `imm_data` is `insn[15:11]` (bits 16–20) zero-extended, and `insn[1]` has no effect.
- R10: `imm_ok` is 1 exactly for select codes 3 to 12. For codes 0, 1, 2 and 13 to 15, `imm_ok` is 0 and `imm_data` is zero whatever the instruction word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| insn | input | 32 | Instruction word |
| sel | input | 4 | Operand-select code |
| imm_data | output | 64 | Generated immediate |
| imm_ok | output | 1 | Immediate valid |

## Verification
The bound checker samples the outputs continuously. It checks the following properties:
- The data is zero whenever the flag is low.
- The low-unsigned and low-signed forms match their field.
- The minus-one constant is all ones.
- The shift forms stay within their width.
- The branch forms keep their two low bits clear.

Some behaviour can only be shown by the bench's scenarios, which compare the outputs against an independent model. These are:
- the exact placement of the high-halfword and branch fields;
- the way the sixth shift bit is split off;
- the sign propagation at the 32-bit boundary;
- the complete silence of the undefined codes, checked over random instruction words.

// File: rtl/imm_operand_gen.sv
module imm_operand_gen #(
  parameter int INSN_W = 32,
  parameter int DATA_W = 64,
  parameter int SEL_W  = 4
) (
  input  logic [INSN_W-1:0] insn,
  input  logic [SEL_W-1:0]  sel,
  output logic [DATA_W-1:0] imm_data,
  output logic              imm_ok
);
  localparam int HALF_W = 16;
  localparam int WORD_W = 32;

  wire [HALF_W-1:0] half_f  = insn[15:0];
  wire [23:0]       long_f  = insn[25:2];
  wire [13:0]       disp_f  = insn[15:2];
  wire [4:0]        sh_lo   = insn[15:11];
  wire              sh_hi   = insn[1];
  wire [WORD_W-1:0] hi_word = {half_f, {HALF_W{1'b0}}};

  always_comb begin
    imm_data = '0;
    imm_ok   = 1'b1;
    case (sel)
      4'd3:    imm_data = {{(DATA_W-HALF_W){1'b0}}, half_f};
      4'd4:    imm_data = {{(DATA_W-HALF_W){half_f[HALF_W-1]}}, half_f};
      4'd5:    imm_data = {{(DATA_W-WORD_W){1'b0}}, hi_word};
      4'd6:    imm_data = {{(DATA_W-WORD_W){hi_word[WORD_W-1]}}, hi_word};
      4'd7:    imm_data = {{(DATA_W-26){1'b0}}, long_f, 2'b00};
      4'd8,
      4'd9:    imm_data = {{(DATA_W-16){1'b0}}, disp_f, 2'b00};
      4'd10:   imm_data = '1;
      4'd11:   imm_data = {{(DATA_W-6){1'b0}}, sh_hi, sh_lo};
      4'd12:   imm_data = {{(DATA_W-5){1'b0}}, sh_lo};
      default: imm_ok = 1'b0;
    endcase
  end
endmodule

module imm_operand_gen_chk (
  input logic [31:0] insn,
  input logic [3:0]  sel,
  input logic [63:0] imm_data,
  input logic        imm_ok
);
  always_comb begin
    // R10
    quiet_when_invalid_chk: assert (imm_ok || imm_data == 64'd0);
    // R1
    low_unsigned_chk: assert (sel != 4'd3 || (imm_ok && imm_data == {48'd0, insn[15:0]}));
    // R2
    low_signed_chk: assert (sel != 4'd4 || (imm_data[15:0] == insn[15:0] && imm_data[63:16] == {48{insn[15]}}));
    // R7
    all_ones_chk: assert (sel != 4'd10 || imm_data == {64{1'b1}});
    // R8
    shift_width_chk: assert (sel != 4'd11 || imm_data[63:6] == 58'd0);
    // R5
    long_align_chk: assert (sel != 4'd7 || imm_data[1:0] == 2'b00);
  end
endmodule

bind imm_operand_gen imm_operand_gen_chk i_chk (
  .insn(insn), .sel(sel), .imm_data(imm_data), .imm_ok(imm_ok)
);

// File: tb/test_imm_operand_gen.sv
module test_imm_operand_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] insn = '0;
  logic [3:0]  sel = '0;
  logic [63:0] imm_data;
  logic        imm_ok;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  imm_operand_gen i_imm_operand_gen (.insn(insn), .sel(sel), .imm_data(imm_data), .imm_ok(imm_ok));

  localparam int NV = 11;
  localparam logic [31:0] TV_INSN [NV] = '{32'h00008000, 32'h00008000, 32'h00001234, 32'h00008001,
    32'h03FFFFFC, 32'h0000FFFF, 32'h12345678, 32'h0000F802, 32'h0000F802, 32'hFFFFFFFF, 32'h0000FFFF};
  localparam logic [3:0]  TV_SEL  [NV] = '{4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd10, 4'd11, 4'd12, 4'd1, 4'd9};
  localparam logic [63:0] TV_EXP  [NV] = '{64'h8000, 64'hFFFFFFFFFFFF8000, 64'h12340000, 64'hFFFFFFFF80010000,
    64'h3FFFFFC, 64'hFFFC, 64'hFFFFFFFFFFFFFFFF, 64'h3F, 64'h1F, 64'h0, 64'hFFFC};
  localparam logic        TV_OK   [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};

  function automatic string tag(input logic [3:0] s);
    case (s)
      4'd3: return "R1"; 4'd4: return "R2"; 4'd5: return "R3"; 4'd6: return "R4";
      4'd7: return "R5"; 4'd8, 4'd9: return "R6"; 4'd10: return "R7";
      4'd11: return "R8"; 4'd12: return "R9"; default: return "R10";
    endcase
  endfunction

  function automatic logic [64:0] model(input logic [31:0] w, input logic [3:0] s);
    logic [63:0] v;
    v = 64'd0;
    case (s)
      4'd3: v = 64'(w[15:0]);
      4'd4: v = 64'($signed(w[15:0]));
      4'd5: v = 64'(w[15:0]) * 64'd65536;
      4'd6: v = 64'($signed({w[15:0], 16'h0}));
      4'd7: v = 64'(w[25:2]) * 64'd4;
      4'd8, 4'd9: v = 64'(w[15:2]) * 64'd4;
      4'd10: v = ~64'd0;
      4'd11: v = 64'(w[15:11]) + (w[1] ? 64'd32 : 64'd0);
      4'd12: v = 64'(w[15:11]);
      default: return 65'd0;
    endcase
    return {1'b1, v};
  endfunction

  task automatic check(input string rq, input logic [63:0] ed, input logic eo);
    n_chk++;
    if (imm_data !== ed || imm_ok !== eo) begin
      n_bad++;
      $display("FAIL %s sel=%0d insn=%h: got %h/%b expected %h/%b", rq, sel, insn, imm_data, imm_ok, ed, eo);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check("R10", 64'd0, 1'b0); // reset-time inputs: sel 0
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk); insn = TV_INSN[i]; sel = TV_SEL[i]; #1;
      check(tag(sel), TV_EXP[i], TV_OK[i]);
    end
    // R9: bit 30 (insn[1]) ignored by the five-bit shift
    @(negedge clk); insn = 32'h00000002; sel = 4'd12; #1;
    check("R9", 64'd0, 1'b0 | 1'b1);
    // R10: undefined codes silent even with all-ones word
    for (int c = 13; c < 16; c++) begin
      @(negedge clk); insn = 32'hFFFFFFFF; sel = 4'(c); #1;
      check("R10", 64'd0, 1'b0);
    end
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); insn = 32'hFFFFFFFF; sel = 4'(c); #1;
      check("R10", 64'd0, 1'b0);
    end
    // R4: sign boundary at bit 31
    @(negedge clk); insn = 32'h00007FFF; sel = 4'd6; #1;
    check("R4", 64'h000000007FFF0000, 1'b1);
    for (int k = 0; k < 60; k++) begin
      for (int c = 0; c < 16; c++) begin
        logic [64:0] e;
        @(negedge clk); insn = $urandom; sel = 4'(c); #1;
        e = model(insn, sel);
        check(tag(sel), e[63:0], e[64]);
      end
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule